// File: doc/BRIEF.md
# I2C Target Byte Engine with Programmable Clock-Stretch Wait

This block is the target (slave) side of an I2C bus with open-drain SCL and SDA. Each bus line comes in as a sampled input and goes out as a drive-low enable. The engine watches for START and STOP conditions and shifts in the 7-bit address and the R/W bit. It compares the address with a programmable own address. On a hit it acknowledges in hardware, and it then services the transfer one byte at a time.

After every byte that concerns it, the engine holds SCL low to stretch the clock. It also raises a one-cycle interrupt, so that local logic has time to read the received byte or supply the next byte to send. A control input picks where the receive-side wait sits: after the 8th SCL falling edge, so that software can see the data before the acknowledge is decided, or after the 9th. In transmit mode the wait sits after the 9th falling edge, once the controller's acknowledge has been sampled. Writing the next transmit byte frees a transmit wait. A separate release strobe frees a receive wait.

Top module: `i2c_wait_target`

## Requirements
- R1: A START (SDA falling while SCL is high) begins a new address byte from bit one, including in the middle of a byte. A STOP (SDA rising while SCL is high) returns the engine to idle with `addressed`=0. Either condition drops any pending SCL hold.
- R2: The address byte arrives MSB first as seven address bits followed by R/W (1 = the controller reads). When the seven bits equal `ownAddr`, the engine pulls SDA low throughout the 9th clock.
- R3: On an address hit, SCL is held low from the 9th falling edge, `irq` pulses, `addressed` goes to 1 and `transmitMode` takes the R/W bit.
- R4: On an address miss, SDA stays released in the 9th clock, no `irq` occurs, SCL is never held, and the bytes that follow are ignored until the next START.
- R5: In receive mode, `rxData` holds the byte (first bit received in bit 7) from the 8th falling edge onward. With `ackEnable`=1, SDA is pulled low in the 9th clock; with `ackEnable`=0, it is left released.
- R6: In receive mode with `waitAt8`=1, the hold and `irq` happen at the 8th falling edge and the 9th edge adds none. With `waitAt8`=0 they happen at the 9th falling edge.
- R7: A one-cycle `waitRelease` frees a receive hold. A `txWrite` during a receive hold leaves SCL held.
- R8: In transmit mode, `txWrite` during the hold loads `txData` and frees SCL. The byte then appears on SDA MSB first, changing only after SCL falling edges. A `waitRelease` during a transmit hold leaves SCL held.
- R9: In transmit mode, `ackDetected` becomes 1 if SDA was low at the 9th rising edge, and 0 if it was high.
- R10: In transmit mode, each byte ends with an SCL hold and an `irq` at the 9th falling edge, and never at the 8th, whatever `waitAt8` is.
- R11: `irq` is high for exactly one clock cycle per event.
- R12: `sdaDriveLow` never changes while the synchronized SCL stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled SCL bus level |
| sdaIn | input | 1 | Sampled SDA bus level |
| sclDriveLow | output | 1 | 1 = pull SCL low (clock-stretch hold) |
| sdaDriveLow | output | 1 | 1 = pull SDA low |
| ownAddr | input | 7 | Address this target answers to |
| txData | input | 8 | Next byte to transmit |
| txWrite | input | 1 | One-cycle strobe: load txData and free a transmit hold |
| waitRelease | input | 1 | One-cycle strobe: free a receive hold |
| waitAt8 | input | 1 | 1 = receive hold at the 8th falling edge, 0 = at the 9th |
| ackEnable | input | 1 | 1 = acknowledge received data bytes |
| rxData | output | 8 | Last received data byte |
| irq | output | 1 | One-cycle event pulse |
| addressed | output | 1 | 1 while selected by a matching address |
| transmitMode | output | 1 | 1 while selected for a controller read |
| ackDetected | output | 1 | Acknowledge seen after the last transmitted byte |

## Verification
The bench builds the engine with a three-stage input synchronizer rather than the default two. This lengthens the delay from a bus edge to the hold. It shows that the hold and the acknowledge drive still land inside the SCL low phase, and that no false START or STOP appears while SDA changes. The bench acts as a controller that waits for SCL to rise (it honours clock stretching). Its transfers cover receive with both wait positions, acknowledged and refused reads, an address miss, and a repeated START in the middle of a byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_BITS = 8;
  localparam int ADDR_W    = BYTE_BITS - 1;
  localparam int CNT_W     = $clog2(BYTE_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_BITS + 1);

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_ADDR = 2'd1,
    MODE_RX   = 2'd2,
    MODE_TX   = 2'd3
  } tgtMode_e;

  // events reported by the datapath
  typedef struct packed {
    logic             startSeen;
    logic             stopSeen;
    logic             sclRise;
    logic             sclFall;
    logic             sclHigh;
    logic [CNT_W-1:0] riseCnt;
    logic             addrHit;
    logic             rwBit;
    logic             txLoaded;
  } busEvt_t;

  // strobes issued by the control
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic captureRx;
    logic sampleAck;
    logic driveAck;
    logic txDrive;
  } dpStrobe_t;
endpackage

// File: rtl/i2c_tgt_datapath.sv
module i2c_tgt_datapath
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic [ADDR_W-1:0]    ownAddr,
  input  logic [BYTE_BITS-1:0] txData,
  input  dpStrobe_t            stb,
  output busEvt_t              evt,
  output logic [BYTE_BITS-1:0] rxData,
  output logic                 ackDetected,
  output logic                 sdaDriveLow
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic riseNow, fallNow, startNow, stopNow;
  logic [CNT_W-1:0] riseCnt;
  logic [BYTE_BITS-1:0] shiftReg;
  logic txLoaded;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= sclIn;
          sdaSync <= sdaIn;
        end
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign riseNow  = sclS & ~sclPrev;
  assign fallNow  = ~sclS & sclPrev;
  assign startNow = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopNow  = sclS & sclPrev & ~sdaPrev & sdaS;

  // rising edges counted inside the current byte (9 = acknowledge bit)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseCnt <= '0;
    end else if (startNow || stopNow) begin
      riseCnt <= '0;
    end else if (riseNow && riseCnt < CNT_ACK) begin
      riseCnt <= riseCnt + 1'b1;
    end else if (fallNow && riseCnt == CNT_ACK) begin
      riseCnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      txLoaded    <= 1'b0;
      rxData      <= '0;
      ackDetected <= 1'b0;
    end else begin
      if (stb.loadTx) begin
        shiftReg <= txData;
      end else if (stb.shiftIn) begin
        shiftReg <= {shiftReg[BYTE_BITS-2:0], sdaS};
      end else if (stb.shiftOut) begin
        shiftReg <= {shiftReg[BYTE_BITS-2:0], 1'b0};
      end
      if (startNow || stopNow) begin
        txLoaded <= 1'b0;
      end else if (stb.loadTx) begin
        txLoaded <= 1'b1;
      end else if (fallNow && riseCnt == CNT_LAST) begin
        txLoaded <= 1'b0;
      end
      if (stb.captureRx) begin
        rxData <= shiftReg;
      end
      if (stb.sampleAck) begin
        ackDetected <= ~sdaS;
      end
    end
  end

  assign sdaDriveLow = stb.driveAck | (stb.txDrive & txLoaded & ~shiftReg[BYTE_BITS-1]);

  always_comb begin
    evt.startSeen = startNow;
    evt.stopSeen  = stopNow;
    evt.sclRise   = riseNow;
    evt.sclFall   = fallNow;
    evt.sclHigh   = sclS;
    evt.riseCnt   = riseCnt;
    evt.addrHit   = (shiftReg[BYTE_BITS-1:1] == ownAddr);
    evt.rwBit     = shiftReg[0];
    evt.txLoaded  = txLoaded;
  end

  // R12
  sda_steady_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclPrev) |-> $stable(sdaDriveLow));

  // R9
  ack_flag_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ackDetected) |-> $past(riseNow));
endmodule

// File: rtl/i2c_tgt_control.sv
module i2c_tgt_control
  import i2c_tgt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  busEvt_t   evt,
  input  logic      txWrite,
  input  logic      waitRelease,
  input  logic      waitAt8,
  input  logic      ackEnable,
  output dpStrobe_t stb,
  output logic      sclDriveLow,
  output logic      irq,
  output logic      addressed,
  output logic      transmitMode
);
  tgtMode_e mode;
  logic waitHold, ackPhase, addrAck, byteWaited;
  logic busCond, atFall8, atFall9;

  assign busCond = evt.startSeen | evt.stopSeen;
  assign atFall8 = evt.sclFall && (evt.riseCnt == CNT_LAST);
  assign atFall9 = evt.sclFall && (evt.riseCnt == CNT_ACK);

  always_comb begin
    stb.shiftIn   = evt.sclRise && (evt.riseCnt < CNT_LAST) &&
                    (mode == MODE_ADDR || mode == MODE_RX);
    stb.shiftOut  = evt.sclFall && (mode == MODE_TX) &&
                    (evt.riseCnt != '0) && (evt.riseCnt < CNT_LAST);
    stb.loadTx    = txWrite && waitHold && (mode == MODE_TX) && !busCond;
    stb.captureRx = atFall8 && (mode == MODE_RX);
    stb.sampleAck = evt.sclRise && (evt.riseCnt == CNT_LAST) && (mode == MODE_TX);
    stb.driveAck  = ackPhase && (addrAck || (mode == MODE_RX && ackEnable));
    stb.txDrive   = (mode == MODE_TX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode       <= MODE_IDLE;
      waitHold   <= 1'b0;
      ackPhase   <= 1'b0;
      addrAck    <= 1'b0;
      byteWaited <= 1'b0;
      irq        <= 1'b0;
    end else if (busCond) begin
      mode       <= evt.startSeen ? MODE_ADDR : MODE_IDLE;
      waitHold   <= 1'b0;
      ackPhase   <= 1'b0;
      addrAck    <= 1'b0;
      byteWaited <= 1'b0;
      irq        <= 1'b0;
    end else begin
      irq <= 1'b0;
      unique case (mode)
        MODE_ADDR: begin
          if (atFall8) begin
            if (evt.addrHit) begin
              ackPhase <= 1'b1;
              addrAck  <= 1'b1;
            end else begin
              mode <= MODE_IDLE;
            end
          end else if (atFall9 && addrAck) begin
            mode     <= evt.rwBit ? MODE_TX : MODE_RX;
            waitHold <= 1'b1;
            irq      <= 1'b1;
            ackPhase <= 1'b0;
            addrAck  <= 1'b0;
          end
        end
        MODE_RX: begin
          if (atFall8) begin
            ackPhase <= 1'b1;
            if (waitAt8) begin
              waitHold   <= 1'b1;
              irq        <= 1'b1;
              byteWaited <= 1'b1;
            end
          end else if (atFall9) begin
            ackPhase   <= 1'b0;
            byteWaited <= 1'b0;
            if (!byteWaited) begin
              waitHold <= 1'b1;
              irq      <= 1'b1;
            end
          end else if (waitRelease && waitHold) begin
            waitHold <= 1'b0;
          end
        end
        MODE_TX: begin
          if (atFall9) begin
            waitHold <= 1'b1;
            irq      <= 1'b1;
          end else if (stb.loadTx) begin
            waitHold <= 1'b0;
          end
        end
        default: begin
        end
      endcase
    end
  end

  assign sclDriveLow  = waitHold;
  assign addressed    = (mode == MODE_RX) || (mode == MODE_TX);
  assign transmitMode = (mode == MODE_TX);

  // R3
  hold_only_selected_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waitHold) |-> (mode == MODE_RX || mode == MODE_TX));

  // R3
  hold_keeps_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    waitHold |-> !evt.sclHigh);

  // R11
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_IDLE) |-> (!irq && !waitHold));

  // R8
  tx_bits_only_in_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.txLoaded |-> (mode == MODE_TX));
endmodule

// File: rtl/i2c_wait_target.sv
module i2c_wait_target
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 sclDriveLow,
  output logic                 sdaDriveLow,
  input  logic [ADDR_W-1:0]    ownAddr,
  input  logic [BYTE_BITS-1:0] txData,
  input  logic                 txWrite,
  input  logic                 waitRelease,
  input  logic                 waitAt8,
  input  logic                 ackEnable,
  output logic [BYTE_BITS-1:0] rxData,
  output logic                 irq,
  output logic                 addressed,
  output logic                 transmitMode,
  output logic                 ackDetected
);
  busEvt_t   evt;
  dpStrobe_t stb;

  i2c_tgt_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ownAddr(ownAddr), .txData(txData), .stb(stb), .evt(evt),
    .rxData(rxData), .ackDetected(ackDetected), .sdaDriveLow(sdaDriveLow)
  );

  i2c_tgt_control u_ctl (
    .clk(clk), .rstN(rstN), .evt(evt), .txWrite(txWrite),
    .waitRelease(waitRelease), .waitAt8(waitAt8), .ackEnable(ackEnable),
    .stb(stb), .sclDriveLow(sclDriveLow), .irq(irq),
    .addressed(addressed), .transmitMode(transmitMode)
  );
endmodule

// File: tb/i2c_wait_target_test.sv
`timescale 1ns/1ps
module i2c_wait_target_test;
  localparam int H = 16;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclBus, sdaBus;
  logic sclDriveLow, sdaDriveLow;
  logic [7:0] txData = 8'h00;
  logic txWrite = 1'b0, waitRelease = 1'b0, waitAt8 = 1'b0, ackEnable = 1'b1;
  logic [7:0] rxData;
  logic irq, addressed, transmitMode, ackDetected;

  int checks = 0;
  int errors = 0;
  int irqCount = 0;
  int irqWideErrs = 0;
  logic irqLast = 1'b0;

  always #4 clk = ~clk;

  assign sclBus = mScl & ~sclDriveLow;
  assign sdaBus = mSda & ~sdaDriveLow;

  i2c_wait_target #(.SYNC_STAGES(3)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .ownAddr(OWN), .txData(txData), .txWrite(txWrite),
    .waitRelease(waitRelease), .waitAt8(waitAt8), .ackEnable(ackEnable),
    .rxData(rxData), .irq(irq), .addressed(addressed),
    .transmitMode(transmitMode), .ackDetected(ackDetected)
  );

  // R11: per-clock pulse-width watch
  always @(negedge clk) begin
    if (rstN) begin
      if (irq) begin
        irqCount++;
        if (irqLast) irqWideErrs++;
      end
      irqLast = irq;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bitCycle(input logic v, output logic seen);
    mSda = v;
    repeat (H) @(negedge clk);
    mScl = 1'b1;
    while (!sclBus) @(negedge clk);
    repeat (H/2) @(negedge clk);
    seen = sdaBus;
    repeat (H/2) @(negedge clk);
    mScl = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic sendBits(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) bitCycle(b[i], s);
  endtask

  task automatic readBits(output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(1'b1, s);
      b[i] = s;
    end
  endtask

  task automatic busStart();
    mSda = 1'b1;
    repeat (H) @(negedge clk);
    mScl = 1'b1;
    while (!sclBus) @(negedge clk);
    repeat (H) @(negedge clk);
    mSda = 1'b0;
    repeat (H) @(negedge clk);
    mScl = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic busStop();
    mSda = 1'b0;
    repeat (H) @(negedge clk);
    mScl = 1'b1;
    while (!sclBus) @(negedge clk);
    repeat (H) @(negedge clk);
    mSda = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic pulseRelease();
    waitRelease = 1'b1;
    @(negedge clk);
    waitRelease = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulseWrite(input logic [7:0] d);
    txData = d;
    txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic finishRun();
    chk(irqWideErrs == 0, "R11", "irq wider than one cycle", irqWideErrs, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic s;
    logic [7:0] rd;
    int irqBefore;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(!sclDriveLow && !sdaDriveLow, "R1", "reset drives", {sclDriveLow, sdaDriveLow}, 0);
    chk(!irq && !addressed, "R1", "reset status", {irq, addressed}, 0);

    // write transfer, wait at 9th edge, ACK enabled
    busStart();
    irqBefore = irqCount;
    sendBits({OWN, 1'b0});
    bitCycle(1'b1, s);
    chk(s == 1'b0, "R2", "address ACK level", s, 0);
    chk(sclDriveLow, "R3", "hold after address", sclDriveLow, 1);
    chk(irqCount == irqBefore + 1, "R3", "address irq", irqCount - irqBefore, 1);
    chk(addressed && !transmitMode, "R3", "addressed/write", {addressed, transmitMode}, 2'b10);
    pulseWrite(8'hEE);
    chk(sclDriveLow, "R7", "txWrite ignored in receive", sclDriveLow, 1);
    pulseRelease();
    chk(!sclDriveLow, "R7", "waitRelease frees receive", sclDriveLow, 0);
    irqBefore = irqCount;
    sendBits(8'hC3);
    chk(!sclDriveLow, "R6", "no hold at 8th with waitAt8=0", sclDriveLow, 0);
    chk(rxData == 8'hC3, "R5", "rxData", rxData, 8'hC3);
    bitCycle(1'b1, s);
    chk(s == 1'b0, "R5", "data ACK", s, 0);
    chk(sclDriveLow, "R6", "hold at 9th", sclDriveLow, 1);
    chk(irqCount == irqBefore + 1, "R6", "irq at 9th", irqCount - irqBefore, 1);
    pulseRelease();

    // wait at 8th, ACK disabled
    waitAt8 = 1'b1;
    ackEnable = 1'b0;
    irqBefore = irqCount;
    sendBits(8'h5A);
    chk(sclDriveLow, "R6", "hold at 8th", sclDriveLow, 1);
    chk(irqCount == irqBefore + 1, "R6", "irq at 8th", irqCount - irqBefore, 1);
    chk(rxData == 8'h5A, "R5", "rxData at 8th", rxData, 8'h5A);
    pulseRelease();
    bitCycle(1'b1, s);
    chk(s == 1'b1, "R5", "NACK when ackEnable=0", s, 1);
    chk(!sclDriveLow, "R6", "no second hold at 9th", sclDriveLow, 0);
    chk(irqCount == irqBefore + 1, "R6", "single irq per byte", irqCount - irqBefore, 1);
    busStop();
    chk(!addressed && !sclDriveLow, "R1", "STOP returns idle", {addressed, sclDriveLow}, 0);

    // address miss
    busStart();
    irqBefore = irqCount;
    sendBits({7'h2B, 1'b0});
    bitCycle(1'b1, s);
    chk(s == 1'b1, "R4", "miss leaves SDA released", s, 1);
    chk(!sclDriveLow, "R4", "miss no hold", sclDriveLow, 0);
    sendBits(8'h00);
    bitCycle(1'b1, s);
    chk(s == 1'b1 && !sclDriveLow, "R4", "following byte ignored", {s, sclDriveLow}, 2'b10);
    chk(irqCount == irqBefore && !addressed, "R4", "miss no irq", irqCount - irqBefore, 0);
    busStop();

    // read transfer (waitAt8 still 1)
    busStart();
    irqBefore = irqCount;
    sendBits({OWN, 1'b1});
    bitCycle(1'b1, s);
    chk(s == 1'b0, "R2", "read address ACK", s, 0);
    chk(sclDriveLow && transmitMode, "R3", "hold and transmit mode", {sclDriveLow, transmitMode}, 2'b11);
    chk(irqCount == irqBefore + 1, "R3", "read address irq", irqCount - irqBefore, 1);
    pulseRelease();
    chk(sclDriveLow, "R8", "waitRelease ignored in transmit", sclDriveLow, 1);
    pulseWrite(8'hA5);
    chk(!sclDriveLow, "R8", "txWrite frees transmit hold", sclDriveLow, 0);
    irqBefore = irqCount;
    readBits(rd);
    chk(rd == 8'hA5, "R8", "transmitted byte", rd, 8'hA5);
    chk(!sclDriveLow, "R10", "no hold at 8th in transmit", sclDriveLow, 0);
    bitCycle(1'b0, s);
    chk(sclDriveLow, "R10", "hold at 9th in transmit", sclDriveLow, 1);
    chk(irqCount == irqBefore + 1, "R10", "transmit irq", irqCount - irqBefore, 1);
    chk(ackDetected, "R9", "ACK recorded", ackDetected, 1);
    pulseWrite(8'h3C);
    readBits(rd);
    chk(rd == 8'h3C, "R8", "second transmitted byte", rd, 8'h3C);
    bitCycle(1'b1, s);
    chk(!ackDetected, "R9", "NACK recorded", ackDetected, 0);
    chk(sclDriveLow, "R10", "hold after NACK", sclDriveLow, 1);
    pulseWrite(8'hFF);
    busStop();
    chk(!addressed && !sclDriveLow, "R1", "STOP after read", {addressed, sclDriveLow}, 0);

    // repeated START in the middle of a byte
    waitAt8 = 1'b0;
    ackEnable = 1'b1;
    busStart();
    sendBits({OWN, 1'b0});
    bitCycle(1'b1, s);
    pulseRelease();
    bitCycle(1'b1, s);
    bitCycle(1'b0, s);
    bitCycle(1'b1, s);
    busStart();
    irqBefore = irqCount;
    sendBits({OWN, 1'b0});
    bitCycle(1'b1, s);
    chk(s == 1'b0, "R1", "ACK after mid-byte START", s, 0);
    chk(sclDriveLow && irqCount == irqBefore + 1, "R1", "hold after restart",
        irqCount - irqBefore, 1);
    pulseRelease();
    busStop();
    chk(!addressed && !sclDriveLow && !sdaDriveLow, "R1", "final idle",
        {addressed, sclDriveLow, sdaDriveLow}, 0);

    finishRun();
  end
endmodule